// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns three active-low reset sources into an ordered set of reset outputs for the rest of the chip. The sources are a power-on input, a bidirectional hard reset pin and a bidirectional soft reset pin. An internal one-cycle request also starts a hard reset. The sources rank in a fixed order. Power-on forces both the hard and the soft reset. Hard forces soft. Soft reset touches only the core logic and leaves the system-configuration domain alone. That domain covers the memory controller, the protection logic, the interrupt controller and the parallel I/O.

The two board pins are open-drain. The block can only pull a pin low, through an output enable, and it reads the pin level back to notice when another device pulls it. A pin assertion is seen only while the block is idle. While the block is driving a reset, any other source is ignored. When the power-on reset is released, five configuration straps are latched into a register. Only a later power-on reset changes that register. A status register records which sources started the most recent reset and stays readable after the reset ends.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Pulling `por_n` low drives `por_rst_n`, `hard_rst_n` and `soft_rst_n` low and both pin enables high at once, with no clock edge needed. During power-on reset `rst_status` reads 4'b0001.
- R2: `por_rst_n` releases on the second rising clock edge after `por_n` goes high. The power-on sequence then holds `hard_rst_n` low for HOLD_CYC cycles (default 16) and `soft_rst_n` low for TAIL_CYC more cycles (default 4). Whenever `hard_rst_n` is low, `soft_rst_n` is also low, and hard always releases first.
- R3: A falling level on the synchronized `hard_pin_n` while the block is idle starts a hard sequence. Hard is held 16 cycles and soft 20 cycles in total. The trigger lands on the third rising edge after the pin falls.
- R4: A falling level on `soft_pin_n` while idle, with no hard source present, holds only `soft_rst_n` low, for 16 cycles. `hard_rst_n` stays high.
- R5: `int_req` sampled high while idle starts the same sequence as an external hard reset.
- R6: While any reset is being driven, pin assertions and `int_req` are ignored. They do not change `rst_status` or lengthen the reset. A pin still held low after the block releases does not start a new reset.
- R7: `rst_status` bit encoding: bit0 is power-on, bit1 is external hard pin, bit2 is external soft pin and bit3 is internal request. Every source present on the trigger edge sets its bit, and all other bits are cleared. The value holds until the next reset. Power-on reset writes 4'b0001.
- R8: The straps are latched on the edge that releases `por_rst_n`. The outputs are `cfg_slave` (0 master, 1 slave), `cfg_debug` (0 normal, 1 debug), `cfg_host_en` (1 enabled) and `cfg_boot[1:0]` (00 external memory, 01 host port). The reserved boot values 10 and 11 are kept as given. Later strap changes and hard or soft resets leave the latched values unchanged.
- R9: `hard_pin_oe` is high exactly while `hard_rst_n` is low, and `soft_pin_oe` is high exactly while `soft_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hard_pin_n | input | 1 | Level read back from the open-drain hard reset pin |
| soft_pin_n | input | 1 | Level read back from the open-drain soft reset pin |
| int_req | input | 1 | Synchronous internal hard reset request |
| strap_slave | input | 1 | Master/slave strap |
| strap_debug | input | 1 | Debug entry strap |
| strap_host_en | input | 1 | Host port enable strap |
| strap_boot | input | 2 | Boot source strap |
| por_rst_n | output | 1 | Internal power-on reset, active low |
| hard_rst_n | output | 1 | System-configuration domain reset, active low |
| soft_rst_n | output | 1 | Core logic reset, active low |
| hard_pin_oe | output | 1 | Pull-down enable for the hard reset pin |
| soft_pin_oe | output | 1 | Pull-down enable for the soft reset pin |
| cfg_slave | output | 1 | Latched master/slave select |
| cfg_debug | output | 1 | Latched debug request |
| cfg_host_en | output | 1 | Latched host port enable |
| cfg_boot | output | 2 | Latched boot source |
| rst_status | output | 4 | Sources of the latest reset |

## Verification
The hardest case to reach is an external assertion that arrives while the block is already holding a reset. A falling edge seen then must not change the status or restart the hold. A pin that stays low past the release must not read as a new event. The bench reaches this case by pulling the hard pin, then pulsing the soft pin and the internal request halfway through the hold window. In a separate run it keeps the hard pin low well past the release. In both runs it measures the exact low duration of every output and counts any second reset.

// File: rtl/rstc_pkg.sv
// Shared types for the reset sequencer.
// Assumes: status bit positions are visible to software and stay fixed.
package rstc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,  // no reset driven
        SEQ_HARD = 2'd1,  // hard and soft held
        SEQ_TAIL = 2'd2,  // hard released, soft still held
        SEQ_SOFT = 2'd3   // soft only
    } seq_state_e;

    localparam int ST_POR      = 0;
    localparam int ST_EXT_HARD = 1;
    localparam int ST_EXT_SOFT = 2;
    localparam int ST_INT      = 3;
    localparam int ST_W        = 4;

    typedef struct packed {
        logic       slave;
        logic       debug;
        logic       host_en;
        logic [1:0] boot;
    } strap_t;

endpackage

// File: rtl/rstc_sync.sv
// Multi-stage level synchronizer.
// ASYNC_CLR picks an asynchronously cleared chain (used for reset release)
// or a synchronously cleared chain (used for pin read-back).
// Assumes: d is a level held for at least STAGES clock cycles.
module rstc_sync #(
    parameter int STAGES    = 2,
    parameter bit ASYNC_CLR = 1'b0,
    parameter bit CLR_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (ASYNC_CLR) begin : g_async
            // Chain cleared at once by rst_n, released through the flops.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{CLR_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_sync
            // Chain cleared on the clock while rst_n is low.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{CLR_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rstc_strap.sv
// Strap capture register.
// Follows the straps while load is high. Freezes on the edge where load
// drops, which is the power-on release edge. No other reset touches it.
module rstc_strap
    import rstc_pkg::*;
(
    input  logic   clk,
    input  logic   load,
    input  strap_t d,
    output strap_t q
);

    // Track the straps during power-on reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (load) q <= d;
    end

endmodule

// File: rtl/rstc_seq.sv
// Reset sequencer core: picks the source, runs the hold counters and keeps
// the status register.
// Assumes: pin levels are already synchronized; int_req is synchronous;
// HOLD_CYC >= 3 and TAIL_CYC >= 1.
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16,
    parameter int TAIL_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hard_lvl_n,
    input  logic            soft_lvl_n,
    input  logic            int_req,
    output logic            hard_act,
    output logic            soft_act,
    output logic [ST_W-1:0] status
);

    localparam int CNT_MAX = (HOLD_CYC > TAIL_CYC) ? HOLD_CYC : TAIL_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             hard_prev, soft_prev;
    logic             hard_fall, soft_fall, idle, go_hard, go_soft;
    logic [ST_W-1:0]  trig_bits;

    // Remember last pin levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_prev <= 1'b1;
            soft_prev <= 1'b1;
        end else begin
            hard_prev <= hard_lvl_n;
            soft_prev <= soft_lvl_n;
        end
    end

    assign hard_fall = hard_prev & ~hard_lvl_n;
    assign soft_fall = soft_prev & ~soft_lvl_n;
    assign idle      = (state == SEQ_IDLE);
    assign go_hard   = idle & (hard_fall | int_req);
    assign go_soft   = idle & soft_fall;

    // Collect every source present on the trigger edge.
    always_comb begin
        trig_bits              = '0;
        trig_bits[ST_EXT_HARD] = hard_fall;
        trig_bits[ST_EXT_SOFT] = soft_fall;
        trig_bits[ST_INT]      = int_req;
    end

    // Next state and hold counter.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        case (state)
            SEQ_IDLE: begin
                cnt_nx = '0;
                if (go_hard)      state_nx = SEQ_HARD;
                else if (go_soft) state_nx = SEQ_SOFT;
            end
            SEQ_HARD: if (cnt == HOLD_LAST) begin state_nx = SEQ_TAIL; cnt_nx = '0; end
            SEQ_TAIL: if (cnt == TAIL_LAST) begin state_nx = SEQ_IDLE; cnt_nx = '0; end
            SEQ_SOFT: if (cnt == HOLD_LAST) begin state_nx = SEQ_IDLE; cnt_nx = '0; end
            default:  begin state_nx = SEQ_IDLE; cnt_nx = '0; end
        endcase
    end

    // Register state and counter; power-on parks the sequence at hard hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_HARD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Status: power-on writes its own bit, a trigger from idle writes its sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status         <= '0;
            status[ST_POR] <= 1'b1;
        end else if (go_hard | go_soft) begin
            status <= trig_bits;
        end
    end

    assign hard_act = (state == SEQ_HARD);
    assign soft_act = (state != SEQ_IDLE);

    AST_HARD_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_act) |-> soft_act);                                    // R2
    AST_SOFT_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_act) |-> !$past(hard_act));                            // R2
    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(status));                                       // R6
    AST_ENTRY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_act) |-> (status != '0));                              // R7

endmodule

// File: rtl/rst_seq_ctrl.sv
// Top of the multi-source reset sequencer.
// The power-on input clears its synchronizer at once, so every output
// asserts without a clock. Release is synchronous. The pins are modelled as
// a pull-down enable plus the read-back level.
// Assumes: straps are stable for a few cycles around power-on release.
module rst_seq_ctrl
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int TAIL_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       hard_pin_n,
    input  logic       soft_pin_n,
    input  logic       int_req,
    input  logic       strap_slave,
    input  logic       strap_debug,
    input  logic       strap_host_en,
    input  logic [1:0] strap_boot,
    output logic       por_rst_n,
    output logic       hard_rst_n,
    output logic       soft_rst_n,
    output logic       hard_pin_oe,
    output logic       soft_pin_oe,
    output logic       cfg_slave,
    output logic       cfg_debug,
    output logic       cfg_host_en,
    output logic [1:0] cfg_boot,
    output logic [3:0] rst_status
);

    logic   por_sync_n, hard_lvl_n, soft_lvl_n, hard_act, soft_act;
    strap_t strap_in, strap_q;

    rstc_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b1), .CLR_VAL(1'b0)) u_por_sync (
        .clk(clk), .rst_n(por_n), .d(1'b1), .q(por_sync_n));

    rstc_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b0), .CLR_VAL(1'b1)) u_hard_sync (
        .clk(clk), .rst_n(por_sync_n), .d(hard_pin_n), .q(hard_lvl_n));

    rstc_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b0), .CLR_VAL(1'b1)) u_soft_sync (
        .clk(clk), .rst_n(por_sync_n), .d(soft_pin_n), .q(soft_lvl_n));

    rstc_seq #(.HOLD_CYC(HOLD_CYC), .TAIL_CYC(TAIL_CYC)) u_seq (
        .clk(clk), .rst_n(por_sync_n), .hard_lvl_n(hard_lvl_n), .soft_lvl_n(soft_lvl_n),
        .int_req(int_req), .hard_act(hard_act), .soft_act(soft_act), .status(rst_status));

    assign strap_in = '{slave: strap_slave, debug: strap_debug,
                        host_en: strap_host_en, boot: strap_boot};

    rstc_strap u_strap (.clk(clk), .load(~por_sync_n), .d(strap_in), .q(strap_q));

    // Power-on gates every output so assertion needs no clock.
    assign por_rst_n   = por_sync_n;
    assign hard_rst_n  = por_sync_n & ~hard_act;
    assign soft_rst_n  = por_sync_n & ~soft_act;
    assign hard_pin_oe = ~hard_rst_n;
    assign soft_pin_oe = ~soft_rst_n;

    assign cfg_slave   = strap_q.slave;
    assign cfg_debug   = strap_q.debug;
    assign cfg_host_en = strap_q.host_en;
    assign cfg_boot    = strap_q.boot;

    AST_POR_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!por_rst_n)
        $rose(por_rst_n) |-> (!hard_rst_n && !soft_rst_n));               // R2
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!por_rst_n)
        $past(por_rst_n) |-> $stable(strap_q));                           // R8

endmodule

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_hard_n = 1'b1, ext_soft_n = 1'b1, int_req = 1'b0;
    logic       strap_slave = 1'b1, strap_debug = 1'b0, strap_host_en = 1'b1;
    logic [1:0] strap_boot = 2'b01;
    logic       hard_pin_n, soft_pin_n;
    logic       por_rst_n, hard_rst_n, soft_rst_n, hard_pin_oe, soft_pin_oe;
    logic       cfg_slave, cfg_debug, cfg_host_en;
    logic [1:0] cfg_boot;
    logic [3:0] rst_status;
    int         checks = 0, errors = 0;
    int         hl, sl, oe_bad, pl;

    always #2 clk = ~clk;

    // Wired-AND pin model: external driver and block pull-down.
    assign hard_pin_n = ext_hard_n & ~hard_pin_oe;
    assign soft_pin_n = ext_soft_n & ~soft_pin_oe;

    rst_seq_ctrl dut_i (
        .clk(clk), .por_n(por_n), .hard_pin_n(hard_pin_n), .soft_pin_n(soft_pin_n),
        .int_req(int_req), .strap_slave(strap_slave), .strap_debug(strap_debug),
        .strap_host_en(strap_host_en), .strap_boot(strap_boot), .por_rst_n(por_rst_n),
        .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n), .hard_pin_oe(hard_pin_oe),
        .soft_pin_oe(soft_pin_oe), .cfg_slave(cfg_slave), .cfg_debug(cfg_debug),
        .cfg_host_en(cfg_host_en), .cfg_boot(cfg_boot), .rst_status(rst_status));

    // Fields: [22] ext hard, [21] ext soft, [20] int, [19:16] status, [15:8] hard len, [7:0] soft len
    localparam int NVEC = 5;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 4'b0010, 8'd16, 8'd20},   // R3 external hard
        {1'b0, 1'b1, 1'b0, 4'b0100, 8'd0,  8'd16},   // R4 external soft
        {1'b0, 1'b0, 1'b1, 4'b1000, 8'd16, 8'd20},   // R5 internal request
        {1'b1, 1'b1, 1'b0, 4'b0110, 8'd16, 8'd20},   // R7 hard and soft together
        {1'b0, 1'b1, 1'b1, 4'b1100, 8'd16, 8'd20}    // R7 internal and soft together
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one scenario from a negedge and count low cycles of each output.
    task automatic run_case(input int h_end, input int s_from, input int s_to,
                            input int int_at, input int window);
        hl = 0; sl = 0; oe_bad = 0;
        for (int c = 0; c < window; c++) begin
            @(negedge clk);
            ext_hard_n = !(c < h_end);
            ext_soft_n = !(c >= s_from && c < s_to);
            int_req    = (c == int_at);
            if (!hard_rst_n) hl++;
            if (!soft_rst_n) sl++;
            if (hard_pin_oe !== !hard_rst_n || soft_pin_oe !== !soft_rst_n) oe_bad++;
        end
        ext_hard_n = 1'b1; ext_soft_n = 1'b1; int_req = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state under power-on.
        repeat (5) @(negedge clk);
        chk("R1 por_rst_n low", por_rst_n, 0);
        chk("R1 hard_rst_n low", hard_rst_n, 0);
        chk("R1 soft_rst_n low", soft_rst_n, 0);
        chk("R1 pin enables", {hard_pin_oe, soft_pin_oe}, 2'b11);
        chk("R1 status por", rst_status, 4'b0001);

        // Power-on release: two-edge sync, then 16 hard and 4 tail cycles.
        por_n = 1'b1;
        hl = 0; sl = 0; pl = 0; oe_bad = 0;
        for (int c = 0; c < 60; c++) begin
            if (c > 0) @(negedge clk);
            if (!por_rst_n) pl++;
            if (por_rst_n && !hard_rst_n) hl++;
            if (por_rst_n && !soft_rst_n) sl++;
            if (hard_pin_oe !== !hard_rst_n || soft_pin_oe !== !soft_rst_n) oe_bad++;
        end
        chk("R2 por release latency", pl, 2);
        chk("R2 hard hold after por", hl, 16);
        chk("R2 soft hold after por", sl, 20);
        chk("R9 pin enables follow outputs", oe_bad, 0);
        chk("R7 status after por", rst_status, 4'b0001);
        chk("R8 straps latched", {cfg_slave, cfg_debug, cfg_host_en, cfg_boot}, 5'b10101);

        // Later strap changes must not reach the register.
        strap_slave = 1'b0; strap_debug = 1'b1; strap_host_en = 1'b0; strap_boot = 2'b10;

        // Vector table walk.
        for (int k = 0; k < NVEC; k++) begin
            run_case(VEC[k][22] ? 3 : 0, VEC[k][21] ? 0 : 99, VEC[k][21] ? 3 : 99,
                     VEC[k][20] ? 2 : -1, 60);
            chk($sformatf("R7 status vec%0d", k), rst_status, VEC[k][19:16]);
            chk($sformatf("R3 hard len vec%0d", k), hl, VEC[k][15:8]);
            chk($sformatf("R4 soft len vec%0d", k), sl, VEC[k][7:0]);
            chk($sformatf("R9 oe vec%0d", k), oe_bad, 0);
        end
        chk("R8 cfg unchanged by resets", {cfg_slave, cfg_debug, cfg_host_en, cfg_boot}, 5'b10101);

        // Sources during an active reset are ignored.
        run_case(3, 8, 11, 9, 60);
        chk("R6 status unchanged by late sources", rst_status, 4'b0010);
        chk("R6 hard not extended", hl, 16);
        chk("R6 soft not extended", sl, 20);

        // Hard pin held low beyond release: no second reset.
        run_case(40, 99, 99, -1, 80);
        chk("R6 held pin hard once", hl, 16);
        chk("R6 held pin soft once", sl, 20);
        chk("R6 held pin status", rst_status, 4'b0010);

        // Second power-on: immediate assertion, status clear, reserved boot value.
        strap_slave = 1'b0; strap_debug = 1'b1; strap_host_en = 1'b0; strap_boot = 2'b11;
        @(negedge clk);
        #1 por_n = 1'b0;
        #1;
        chk("R1 immediate por_rst_n", por_rst_n, 0);
        chk("R1 immediate hard/soft", {hard_rst_n, soft_rst_n}, 2'b00);
        chk("R1 immediate pin enables", {hard_pin_oe, soft_pin_oe}, 2'b11);
        repeat (4) @(negedge clk);
        chk("R7 status cleared by por", rst_status, 4'b0001);
        por_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 reserved boot latched", {cfg_slave, cfg_debug, cfg_host_en, cfg_boot}, 5'b01011);
        chk("R2 all released", {por_rst_n, hard_rst_n, soft_rst_n}, 3'b111);

        // Soft-only reset leaves hard alone.
        run_case(0, 0, 3, -1, 40);
        chk("R4 soft-only hard len", hl, 0);
        chk("R4 soft-only soft len", sl, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule